// File: doc/BRIEF.md
# Averaging Conversion Result Formatter

This block sits behind an analog-to-digital converter and turns a stream of raw 12-bit results into finished output words. Every result arrives with a 4-bit channel tag and a one-cycle valid strobe. The block averages a selectable power-of-two number of consecutive results from the same channel. It then packs the 16-bit data field, plus an optional 4-bit trailer, into an output word of 16 or 20 bits.

The data field holds the average with four fractional bits. Without averaging, it holds the raw result shifted up by four. Configuration inputs choose the trailer: none, the channel tag, or four caller-supplied status flags. A further input replaces the data field with a constant debug pattern, which lets the word path be tested without converter data. A partial group is discarded when the averaging code changes. It is also discarded when a result from another channel arrives before the group is complete.

Top module: `avg_result_formatter`

## Requirements
- R1: With `ratio_code` = 0, every accepted sample produces a word in the next cycle whose data field is the sample shifted left by 4 bits.
- R2: With `ratio_code` = k (1 to 7), one word is produced per 2^k accepted samples of one channel, with data field = (sum of the samples × 16) >> k, truncated to 16 bits.
- R3: `out_valid` is a single-cycle pulse in the cycle after the sample that completes a group, and it is low in every cycle that does not follow such a sample.
- R4: A sample whose channel differs from the channel of a non-empty partial group discards that group, and the new sample starts a fresh group.
- R5: A change of `ratio_code` discards any partial group, and a sample in the cycle of the change counts as the first sample of a group under the new code.
- R6: With `append_sel` = 00 or the reserved 11, `out_wide` = 0 and `out_word` = {4'b0000, data field}.
- R7: With `append_sel` = 01, `out_wide` = 1 and `out_word` = {data field, channel of the completing sample}.
- R8: With `append_sel` = 10, `out_wide` = 1 and `out_word` = {data field, `status_flags` as seen in the completing sample's cycle}.
- R9: With `fixed_pat` = 1 in the completing sample's cycle, the data field is 0xA5A5, while trailer and timing follow R3 and R6 to R8.
- R10: During and directly after reset, `out_valid`, `out_word` and `out_wide` are 0 and no partial group is held.
- R11: `out_word` and `out_wide` keep their last values in cycles where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 12 | Raw conversion result |
| in_chan | input | 4 | Channel tag of the sample |
| ratio_code | input | 3 | Averaging code, group size 2^code |
| append_sel | input | 2 | Trailer select: 00 none, 01 channel, 10 flags, 11 none |
| fixed_pat | input | 1 | Replace data field with 0xA5A5 |
| status_flags | input | 4 | Flags placed in the trailer when selected |
| out_valid | output | 1 | Word strobe |
| out_word | output | 20 | Output word; 16-bit words sit in bits 15:0 |
| out_wide | output | 1 | 1 when the word carries a 4-bit trailer (20 bits) |

## Verification
Several rules are checked by embedded properties in every cycle:
- the partial-group count stays below the group size for the current code;
- a code change without a sample empties the group;
- no word appears without a sample in the cycle before;
- a pass-through sample always yields a word;
- a 16-bit word has zero upper bits;
- the word holds between pulses.

Only the bench's scenarios can show that the average values are correct, and that a channel switch or code switch restarts the group at exactly the right sample. The same holds for the trailer contents and the debug pattern override. For those checks, a behavioural model is compared against the outputs on every clock.

// File: rtl/avg_fmt_pkg.sv
package avg_fmt_pkg;
  typedef enum logic [1:0] {
    TRL_NONE  = 2'b00,
    TRL_CHAN  = 2'b01,
    TRL_FLAGS = 2'b10,
    TRL_RSVD  = 2'b11
  } trail_sel_e;

  localparam logic [15:0] DEBUG_WORD = 16'hA5A5;
endpackage

// File: rtl/avg_accum.sv
module avg_accum #(
  parameter int DATA_W = 12,
  parameter int CHAN_W = 4,
  parameter int CODE_W = 3,
  parameter int FRAC_W = 4,
  localparam int MAXSH = (1 << CODE_W) - 1,
  localparam int ACC_W = DATA_W + MAXSH,
  localparam int CNT_W = MAXSH + 1,
  localparam int RES_W = DATA_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              grp_done,
  output logic [RES_W-1:0]  grp_result
);
  logic [ACC_W-1:0]  sum_q, sum_d, base_sum, new_sum;
  logic [CNT_W-1:0]  cnt_q, cnt_d, base_cnt, new_cnt, target;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [CODE_W-1:0] code_q;
  logic              restart;
  logic [ACC_W+FRAC_W-1:0] scaled;

  always_comb begin
    target   = CNT_W'(1) << ratio_code;
    restart  = (ratio_code != code_q) ||
               (in_valid && (cnt_q != '0) && (in_chan != chan_q));
    base_sum = restart ? '0 : sum_q;
    base_cnt = restart ? '0 : cnt_q;
    new_sum  = base_sum + ACC_W'(in_data);
    new_cnt  = base_cnt + CNT_W'(1);
    scaled   = {new_sum, {FRAC_W{1'b0}}} >> ratio_code;
    grp_done   = 1'b0;
    grp_result = scaled[RES_W-1:0];
    sum_d    = base_sum;
    cnt_d    = base_cnt;
    chan_d   = chan_q;
    if (in_valid) begin
      chan_d = in_chan;
      if (new_cnt == target) begin
        grp_done = 1'b1;
        sum_d    = '0;
        cnt_d    = '0;
      end else begin
        sum_d = new_sum;
        cnt_d = new_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      chan_q <= '0;
      code_q <= '0;
    end else begin
      sum_q  <= sum_d;
      cnt_q  <= cnt_d;
      chan_q <= chan_d;
      code_q <= ratio_code;
    end
  end

  // R2: a held partial group is always smaller than its group size
  assert_partial_below_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < ((CNT_W+1)'(1) << code_q)));

  // R5: a code change with no sample leaves the group empty
  assert_code_change_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ratio_code != code_q) && !in_valid) |=> (cnt_q == '0));
endmodule

// File: rtl/avg_word_pack.sv
module avg_word_pack
  import avg_fmt_pkg::*;
#(
  parameter int RES_W  = 16,
  parameter int CHAN_W = 4,
  parameter int TRL_W  = 4,
  localparam int WORD_W = RES_W + TRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_done,
  input  logic [RES_W-1:0]  grp_result,
  input  logic [CHAN_W-1:0] grp_chan,
  input  logic [TRL_W-1:0]  status_flags,
  input  logic [1:0]        append_sel,
  input  logic              fixed_pat,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_wide
);
  logic [RES_W-1:0]  field;
  logic [WORD_W-1:0] word_d;
  logic              wide_d;
  trail_sel_e        sel;

  always_comb begin
    sel   = trail_sel_e'(append_sel);
    field = fixed_pat ? RES_W'(DEBUG_WORD) : grp_result;
    case (sel)
      TRL_CHAN: begin
        word_d = {field, TRL_W'(grp_chan)};
        wide_d = 1'b1;
      end
      TRL_FLAGS: begin
        word_d = {field, status_flags};
        wide_d = 1'b1;
      end
      default: begin
        word_d = {{TRL_W{1'b0}}, field};
        wide_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_wide  <= 1'b0;
    end else begin
      out_valid <= grp_done;
      if (grp_done) begin
        out_word <= word_d;
        out_wide <= wide_d;
      end
    end
  end

  // R6: a word without trailer has zero upper bits
  assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wide) |-> (out_word[WORD_W-1:RES_W] == '0));

  // R11: word and width hold between pulses
  assert_word_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_word) && $stable(out_wide)));
endmodule

// File: rtl/avg_result_formatter.sv
module avg_result_formatter #(
  parameter int DATA_W = 12,
  parameter int CHAN_W = 4,
  parameter int CODE_W = 3,
  parameter int FRAC_W = 4,
  parameter int TRL_W  = 4,
  localparam int RES_W  = DATA_W + FRAC_W,
  localparam int WORD_W = RES_W + TRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [CODE_W-1:0] ratio_code,
  input  logic [1:0]        append_sel,
  input  logic              fixed_pat,
  input  logic [TRL_W-1:0]  status_flags,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_wide
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             grp_done;
  logic [RES_W-1:0] grp_result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  avg_accum #(
    .DATA_W(DATA_W), .CHAN_W(CHAN_W), .CODE_W(CODE_W), .FRAC_W(FRAC_W)
  ) accum_i (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_data(in_data),
    .in_chan(in_chan), .ratio_code(ratio_code),
    .grp_done(grp_done), .grp_result(grp_result)
  );

  avg_word_pack #(
    .RES_W(RES_W), .CHAN_W(CHAN_W), .TRL_W(TRL_W)
  ) pack_i (
    .clk(clk), .rst_n(rst_sync_n), .grp_done(grp_done), .grp_result(grp_result),
    .grp_chan(in_chan), .status_flags(status_flags), .append_sel(append_sel),
    .fixed_pat(fixed_pat), .out_valid(out_valid), .out_word(out_word),
    .out_wide(out_wide)
  );

  // R3: no word without a sample in the cycle before
  assert_no_pulse_without_sample_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  // R1: pass-through samples always yield a word
  assert_passthrough_emits_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (ratio_code == '0)) |=> out_valid);
endmodule

// File: tb/avg_result_formatter_tb_top.sv
module avg_result_formatter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_data = '0;
  logic [3:0]  in_chan = '0;
  logic [2:0]  ratio_code = '0;
  logic [1:0]  append_sel = '0;
  logic        fixed_pat = 1'b0;
  logic [3:0]  status_flags = '0;
  logic        out_valid;
  logic [19:0] out_word;
  logic        out_wide;

  always #4 clk = ~clk;

  avg_result_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_chan(in_chan), .ratio_code(ratio_code), .append_sel(append_sel),
    .fixed_pat(fixed_pat), .status_flags(status_flags),
    .out_valid(out_valid), .out_word(out_word), .out_wide(out_wide)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  int    cycles = 0;
  bit    comparing = 0;
  bit    done_run = 0;
  string cur_req = "R10";

  // behavioural reference
  longint m_sum = 0;
  int     m_cnt = 0;
  int     m_chan = 0;
  int     m_code = 0;
  bit     exp_valid = 0;
  logic [19:0] exp_word = '0;
  bit     exp_wide = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sum = 0; m_cnt = 0; m_chan = 0; m_code = 0;
      exp_valid = 0; exp_word = '0; exp_wide = 0;
    end else begin
      int tgt;
      longint avg;
      logic [15:0] d16;
      tgt = 1 << ratio_code;
      if ((int'(ratio_code) != m_code) ||
          (in_valid && m_cnt != 0 && int'(in_chan) != m_chan)) begin
        m_sum = 0; m_cnt = 0;
      end
      exp_valid = 0;
      if (in_valid) begin
        m_sum += in_data;
        m_cnt += 1;
        m_chan = in_chan;
        if (m_cnt == tgt) begin
          avg = (m_sum * 16) >> ratio_code;
          d16 = fixed_pat ? 16'hA5A5 : avg[15:0];
          exp_valid = 1;
          case (append_sel)
            2'b01: begin exp_word = {d16, in_chan}; exp_wide = 1; end
            2'b10: begin exp_word = {d16, status_flags}; exp_wide = 1; end
            default: begin exp_word = {4'b0, d16}; exp_wide = 0; end
          endcase
          m_sum = 0; m_cnt = 0;
        end
      end
      m_code = ratio_code;
    end
  end

  task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: valid/wide/word actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing)
      check(cur_req, {out_valid, out_wide, out_word}, {exp_valid, exp_wide, exp_word});
  end

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
    end
  end

  task automatic put(input bit v, input logic [11:0] d, input logic [3:0] ch);
    @(negedge clk);
    in_valid = v; in_data = d; in_chan = ch;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 12'h000, in_chan);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    check("R10", {out_valid, out_wide, out_word}, 22'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", {out_valid, out_wide, out_word}, 22'h0);
    comparing = 1;

    cur_req = "R1";
    put(1, 12'hFFF, 4'd0); put(1, 12'h000, 4'd1); put(1, 12'h123, 4'd2);
    put(0, 0, 4'd2); put(1, 12'h801, 4'd3);
    cur_req = "R11"; idle(5);

    cur_req = "R2"; ratio_code = 3'd2;
    put(1, 12'h010, 4'd1); put(1, 12'h011, 4'd1); put(1, 12'h013, 4'd1); put(1, 12'h017, 4'd1);
    idle(2);
    ratio_code = 3'd3;
    for (int i = 0; i < 8; i++) begin
      put(1, 12'((i * 397 + 5) & 12'hFFF), 4'd5);
      if (i % 3 == 0) put(0, 0, 4'd5);
    end
    idle(2);
    ratio_code = 3'd7;
    for (int i = 0; i < 128; i++) put(1, 12'hFFF, 4'd6);
    idle(2);
    ratio_code = 3'd5;
    for (int i = 0; i < 64; i++) put(1, 12'((i * 1237 + 99) & 12'hFFF), 4'd7);
    idle(2);

    cur_req = "R4"; ratio_code = 3'd2;
    put(1, 12'h100, 4'd1); put(1, 12'h200, 4'd1);
    put(1, 12'h300, 4'd2); put(1, 12'h301, 4'd2); put(1, 12'h302, 4'd2); put(1, 12'h303, 4'd2);
    idle(2);

    cur_req = "R5"; ratio_code = 3'd3;
    put(1, 12'h050, 4'd4); put(1, 12'h060, 4'd4); put(1, 12'h070, 4'd4);
    @(negedge clk); ratio_code = 3'd1; in_valid = 1; in_data = 12'h400; in_chan = 4'd4;
    put(1, 12'h402, 4'd4);
    put(1, 12'h010, 4'd4); ratio_code = 3'd2; put(0, 0, 4'd4);
    ratio_code = 3'd1; put(0, 0, 4'd4);
    put(1, 12'h020, 4'd4); put(1, 12'h022, 4'd4);
    idle(2);

    ratio_code = 3'd1;
    cur_req = "R7"; append_sel = 2'b01;
    put(1, 12'hABC, 4'd9); put(1, 12'hABE, 4'd9); idle(1);
    cur_req = "R8"; append_sel = 2'b10; status_flags = 4'b1010;
    put(1, 12'h111, 4'd3); status_flags = 4'b0101; put(1, 12'h333, 4'd3);
    status_flags = 4'b1111; idle(1);
    cur_req = "R6"; append_sel = 2'b11;
    put(1, 12'hFFE, 4'd8); put(1, 12'hFFF, 4'd8); idle(1);
    append_sel = 2'b00; ratio_code = 3'd0;
    put(1, 12'h5A5, 4'd2); idle(1);
    cur_req = "R9"; fixed_pat = 1'b1;
    put(1, 12'h001, 4'd2); append_sel = 2'b01; put(1, 12'h002, 4'd11);
    append_sel = 2'b10; put(1, 12'h003, 4'd12);
    ratio_code = 3'd2;
    for (int i = 0; i < 4; i++) put(1, 12'h777, 4'd1);
    idle(2);
    fixed_pat = 1'b0;
    cur_req = "R3"; ratio_code = 3'd1; append_sel = 2'b00;
    for (int i = 0; i < 10; i++) put(1, 12'(i * 300), 4'd0);
    idle(4);
    comparing = 0;
    finish_run();
  end
endmodule